// File: doc/BRIEF.md
# Condition Register Unit

This block holds a 32-bit condition register made of eight 4-bit fields. Three kinds of update can change it.

- **Compare.** A signed compare of two 32-bit operands writes the less-than, greater-than and equal flags of one chosen field. It also copies the incoming summary-overflow bit into the same field.
- **Bit operation.** An eight-way boolean operation takes any two single bits of the register and writes the result into any third bit.
- **Whole-word load.** The entire register is replaced by a move word.

The full register is always visible on an output, so a whole-word read needs no extra path. A combinational branch helper picks one flag of one field and reports whether it matches a required polarity. For example, "branch if greater or equal" asks for the LT flag of a field with polarity 0.

Each cycle, a small arbiter picks one action, named by the states ACT_IDLE, ACT_LOAD, ACT_CMP and ACT_BIT. Priority runs load first, then compare, then bit operation. Requests that lose the arbitration are dropped. The transitions are per cycle and carry no memory:

- any cycle with `load_en` goes to ACT_LOAD;
- otherwise `cmp_en` goes to ACT_CMP;
- otherwise `bop_en` goes to ACT_BIT;
- otherwise the cycle is ACT_IDLE.

Top module: `cond_reg_unit`

## Requirements
- R1: After reset the register reads all zeros.
- R2: A compare treats both operands as signed 32-bit values. It writes field f, which is register bits [31-4f : 28-4f]. That field receives, from MSB to LSB, {LT, GT, EQ, SO}, and exactly one of LT, GT and EQ is set. All other fields keep their values.
- R3: The SO bit written by a compare equals `so_in` in that cycle.
- R4: Bit index i refers to `cr_out[31-i]`, so index 0 is the MSB. The flag k of field f (LT=0, GT=1, EQ=2, SO=3) has index 4f+k.
- R5: A bit operation writes bit D from bits A and B and changes no other bit. The opcodes are:
  - 0: A&B
  - 1: A&~B
  - 2: ~(A^B)
  - 3: ~(A&B)
  - 4: ~(A|B)
  - 5: A|B
  - 6: A|~B
  - 7: A^B
- R6: When D equals A or B, both operands are the values held before the update, and the result lands in a single cycle.
- R7: A load replaces all 32 bits with `load_word` on the next edge. With no request, the register holds its value.
- R8: Load beats compare, and compare beats bit operation. A losing request in the same cycle leaves no trace in the register.
- R9: `br_taken` is 1 exactly when register bit 4*`br_field`+`br_flag` (numbered as in R4) equals `br_pol`. It follows the register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Whole-word load request |
| load_word | input | 32 | Word to load |
| cmp_en | input | 1 | Compare request |
| cmp_a | input | 32 | Signed left operand |
| cmp_b | input | 32 | Signed right operand |
| cmp_field | input | 3 | Field written by the compare |
| so_in | input | 1 | Summary-overflow bit copied into the field |
| bop_en | input | 1 | Bit-operation request |
| bop_op | input | 3 | Bit-operation opcode (R5) |
| bop_a | input | 5 | Index of operand bit A |
| bop_b | input | 5 | Index of operand bit B |
| bop_d | input | 5 | Index of destination bit D |
| br_field | input | 3 | Field tested by the branch helper |
| br_flag | input | 2 | Flag tested (LT=0, GT=1, EQ=2, SO=3) |
| br_pol | input | 1 | Required value of the tested flag |
| cr_out | output | 32 | Current register contents |
| br_taken | output | 1 | Branch-condition result |

## Verification
Any two of load, compare and bit operation can be requested in the same cycle. The bench does this on purpose, using two combinations:
- a load together with a compare and a bit operation;
- a compare together with a bit operation whose destination lies outside the compared field.

The scoreboard predicts that only the winning action shows in `cr_out` after the edge. In the second combination, the untouched destination bit must keep its old value. Overlapping D with A or B is checked the same way, against values taken before the update.

// File: rtl/cru_pkg.sv
package cru_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_CMP  = 2'd2,
        ACT_BIT  = 2'd3
    } act_e;

    typedef enum logic [2:0] {
        BOP_AND  = 3'd0,
        BOP_ANDC = 3'd1,
        BOP_EQV  = 3'd2,
        BOP_NAND = 3'd3,
        BOP_NOR  = 3'd4,
        BOP_OR   = 3'd5,
        BOP_ORC  = 3'd6,
        BOP_XOR  = 3'd7
    } bop_e;

endpackage

// File: rtl/cru_compare.sv
module cru_compare #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [2:0]    flags   // {LT, GT, EQ}
);
    logic lt, gt, eq;

    always_comb begin
        lt    = $signed(op_a) < $signed(op_b);
        gt    = $signed(op_a) > $signed(op_b);
        eq    = (op_a == op_b);
        flags = {lt, gt, eq};
    end

    // R2: the three relations are mutually exclusive and one always holds
    always_comb begin
        assert_cmp_onehot_R2: assert ($countones(flags) == 1);
    end
endmodule

// File: rtl/cru_bitop.sv
module cru_bitop
    import cru_pkg::*;
#(
    parameter int W    = 32,
    parameter int IDXW = $clog2(W)
) (
    input  logic [W-1:0]    word,
    input  logic [IDXW-1:0] idx_a,
    input  logic [IDXW-1:0] idx_b,
    input  logic [2:0]      op,
    output logic            res
);
    localparam logic [IDXW-1:0] TOP = IDXW'(W - 1);

    logic va, vb;

    always_comb begin
        va = word[TOP - idx_a];
        vb = word[TOP - idx_b];
        unique case (bop_e'(op))
            BOP_AND:  res = va & vb;
            BOP_ANDC: res = va & ~vb;
            BOP_EQV:  res = ~(va ^ vb);
            BOP_NAND: res = ~(va & vb);
            BOP_NOR:  res = ~(va | vb);
            BOP_OR:   res = va | vb;
            BOP_ORC:  res = va | ~vb;
            BOP_XOR:  res = va ^ vb;
            default:  res = 1'b0;
        endcase
    end
endmodule

// File: rtl/cru_branch.sv
module cru_branch #(
    parameter int NFIELD = 8,
    parameter int FW     = 4,
    parameter int W      = NFIELD * FW,
    parameter int IDXW   = $clog2(W),
    parameter int FSELW  = $clog2(NFIELD),
    parameter int FLGW   = $clog2(FW)
) (
    input  logic [W-1:0]     word,
    input  logic [FSELW-1:0] field,
    input  logic [FLGW-1:0]  flag,
    input  logic             pol,
    output logic             taken
);
    localparam logic [IDXW-1:0] TOP = IDXW'(W - 1);

    logic [IDXW-1:0] pos;

    always_comb begin
        pos   = IDXW'(field) * IDXW'(FW) + IDXW'(flag);
        taken = (word[TOP - pos] == pol);
    end
endmodule

// File: rtl/cond_reg_unit.sv
module cond_reg_unit
    import cru_pkg::*;
#(
    parameter int NFIELD = 8,
    parameter int FW     = 4,
    parameter int DW     = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_en,
    input  logic [NFIELD*FW-1:0]        load_word,
    input  logic                        cmp_en,
    input  logic [DW-1:0]               cmp_a,
    input  logic [DW-1:0]               cmp_b,
    input  logic [$clog2(NFIELD)-1:0]   cmp_field,
    input  logic                        so_in,
    input  logic                        bop_en,
    input  logic [2:0]                  bop_op,
    input  logic [$clog2(NFIELD*FW)-1:0] bop_a,
    input  logic [$clog2(NFIELD*FW)-1:0] bop_b,
    input  logic [$clog2(NFIELD*FW)-1:0] bop_d,
    input  logic [$clog2(NFIELD)-1:0]   br_field,
    input  logic [$clog2(FW)-1:0]       br_flag,
    input  logic                        br_pol,
    output logic [NFIELD*FW-1:0]        cr_out,
    output logic                        br_taken
);
    localparam int W     = NFIELD * FW;
    localparam int IDXW  = $clog2(W);
    localparam int FSELW = $clog2(NFIELD);
    localparam logic [IDXW-1:0] TOP   = IDXW'(W - 1);
    localparam logic [W-1:0]    FMASK = {{FW{1'b1}}, {(W-FW){1'b0}}};

    act_e         act;
    logic [W-1:0] cr_q, cr_d, cmp_word;
    logic [2:0]   cmp_flags;
    logic         bop_res;

    cru_compare #(.DW(DW)) u_cmp (
        .op_a (cmp_a),
        .op_b (cmp_b),
        .flags(cmp_flags)
    );

    cru_bitop #(.W(W), .IDXW(IDXW)) u_bop (
        .word (cr_q),
        .idx_a(bop_a),
        .idx_b(bop_b),
        .op   (bop_op),
        .res  (bop_res)
    );

    cru_branch #(.NFIELD(NFIELD), .FW(FW)) u_br (
        .word (cr_q),
        .field(br_field),
        .flag (br_flag),
        .pol  (br_pol),
        .taken(br_taken)
    );

    // per-field replacement word for a compare
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        localparam int HI = W - 1 - g * FW;
        assign cmp_word[HI -: FW] = (cmp_field == FSELW'(g))
                                    ? {cmp_flags, {(FW-3){so_in}}}
                                    : cr_q[HI -: FW];
    end

    // action arbitration: load > compare > bit-op
    always_comb begin
        if (load_en)      act = ACT_LOAD;
        else if (cmp_en)  act = ACT_CMP;
        else if (bop_en)  act = ACT_BIT;
        else              act = ACT_IDLE;
    end

    always_comb begin
        cr_d = cr_q;
        unique case (act)
            ACT_IDLE: cr_d = cr_q;
            ACT_LOAD: cr_d = load_word;
            ACT_CMP:  cr_d = cmp_word;
            ACT_BIT:  cr_d[TOP - bop_d] = bop_res;
            default:  cr_d = cr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    assign cr_out = cr_q;

    function automatic logic [FW-1:0] nib(input logic [W-1:0] w, input logic [FSELW-1:0] f);
        nib = w[W - 1 - int'(f) * FW -: FW];
    endfunction

    // R2: only the compared field may change
    assert_cmp_fieldonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CMP) |=> (((cr_q ^ $past(cr_q)) & ~(FMASK >> (int'($past(cmp_field)) * FW))) == '0));
    // R2: exactly one relation flag in the written field
    assert_cmp_one_rel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CMP) |=> ($countones(nib(cr_q, $past(cmp_field)) & {{(FW-1){1'b1}}, 1'b0}) == 1));
    // R3: SO copied from the input
    assert_so_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CMP) |=> (((nib(cr_q, $past(cmp_field)) & FW'(1)) != '0) == $past(so_in)));
    // R5: a bit-op touches at most one bit
    assert_bop_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_BIT) |=> ($countones(cr_q ^ $past(cr_q)) <= 1));
    // R7: load takes the whole word
    assert_load_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cr_q == $past(load_word)));
    // R7: no request, no change
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !cmp_en && !bop_en) |=> $stable(cr_q));
    // R8: load wins against simultaneous requests
    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && (cmp_en || bop_en)) |=> (cr_q == $past(load_word)));
endmodule

// File: tb/cond_reg_unit_tb.sv
module cond_reg_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [31:0] load_word = '0;
    logic        cmp_en = 1'b0;
    logic [31:0] cmp_a = '0, cmp_b = '0;
    logic [2:0]  cmp_field = '0;
    logic        so_in = 1'b0;
    logic        bop_en = 1'b0;
    logic [2:0]  bop_op = '0;
    logic [4:0]  bop_a = '0, bop_b = '0, bop_d = '0;
    logic [2:0]  br_field = '0;
    logic [1:0]  br_flag = '0;
    logic        br_pol = 1'b0;
    logic [31:0] cr_out;
    logic        br_taken;

    cond_reg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_word(load_word),
        .cmp_en(cmp_en), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_field(cmp_field), .so_in(so_in),
        .bop_en(bop_en), .bop_op(bop_op), .bop_a(bop_a), .bop_b(bop_b), .bop_d(bop_d),
        .br_field(br_field), .br_flag(br_flag), .br_pol(br_pol),
        .cr_out(cr_out), .br_taken(br_taken)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic [31:0] cr;
        logic        tk;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] m = '0;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    function automatic logic bop_model(input logic [2:0] op, input logic a, input logic b);
        case (op)
            3'd0: return a & b;
            3'd1: return a & !b;
            3'd2: return a == b;
            3'd3: return !(a & b);
            3'd4: return !(a | b);
            3'd5: return a | b;
            3'd6: return a | !b;
            default: return a ^ b;
        endcase
    endfunction

    // driver: applies one cycle of stimulus and pushes the prediction
    task automatic drive(input logic ld, input logic [31:0] lw,
                         input logic ce, input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] f, input logic so,
                         input logic be, input logic [2:0] op,
                         input logic [4:0] ia, input logic [4:0] ib, input logic [4:0] id,
                         input logic [2:0] bf, input logic [1:0] bg, input logic bp,
                         input string tag);
        exp_t e;
        logic [3:0] nb;
        @(negedge clk);
        load_en = ld; load_word = lw; cmp_en = ce; cmp_a = a; cmp_b = b;
        cmp_field = f; so_in = so; bop_en = be; bop_op = op;
        bop_a = ia; bop_b = ib; bop_d = id; br_field = bf; br_flag = bg; br_pol = bp;
        if (ld) m = lw;
        else if (ce) begin
            nb = {$signed(a) < $signed(b), $signed(a) > $signed(b), a == b, so};
            m[31 - 4*f -: 4] = nb;
        end else if (be) m[31 - id] = bop_model(op, m[31 - ia], m[31 - ib]);
        e.cr  = m;
        e.tk  = (m[31 - (4*bf + bg)] == bp);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(0, '0, 0, '0, '0, 3'd0, 0, 0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 2'd0, 1'b0, tag);
    endtask

    task automatic bop(input logic [2:0] op, input logic [4:0] ia, input logic [4:0] ib,
                       input logic [4:0] id, input string tag);
        drive(0, '0, 0, '0, '0, 3'd0, 0, 1, op, ia, ib, id, 3'd0, 2'd0, 1'b0, tag);
    endtask

    // monitor: compares after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                if (cr_out !== e.cr || br_taken !== e.tk) begin
                    errors++;
                    $display("FAIL %s: cr=%h taken=%b expected cr=%h taken=%b",
                             e.tag, cr_out, br_taken, e.cr, e.tk);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle("R1 reset state");
        idle("R1 reset state held");
        @(negedge clk); rst_n = 1'b1;
        idle("R7 idle after reset");
        // R7 whole-word load
        drive(1, 32'h1234_5678, 0, '0, '0, 3'd0, 0, 0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 2'd0, 1'b0, "R7 load");
        drive(0, '0, 0, '0, '0, 3'd0, 0, 0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 2'd0, 1'b0, "R7 hold");
        // R2/R3 compares on several fields
        drive(0, '0, 1, 32'd5, 32'd7, 3'd0, 1, 0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd0, 2'd0, 1'b0, "R2 R3 field0 less");
        drive(0, '0, 1, 32'hFFFF_FFFF, 32'd1, 3'd7, 0, 0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd7, 2'd0, 1'b0, "R2 R9 signed less, bge not taken");
        drive(0, '0, 1, 32'd1, 32'hFFFF_FFFE, 3'd5, 1, 0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd5, 2'd0, 1'b0, "R2 R9 signed greater, bge taken");
        drive(0, '0, 1, 32'h8000_0000, 32'h8000_0000, 3'd3, 0, 0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd3, 2'd2, 1'b1, "R2 R9 equal, eq branch");
        drive(0, '0, 1, 32'd9, 32'd9, 3'd6, 1, 0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd6, 2'd3, 1'b1, "R3 R4 so bit of field6");
        // R4 R6 bit-ops, including index 2 <- 26 op 30
        bop(3'd0, 5'd26, 5'd30, 5'd2, "R4 R5 and eq bits");
        for (int k = 0; k < 8; k++) begin
            bop(3'(k), 5'(3*k + 1), 5'(31 - 2*k), 5'(4*k + 2), "R5 opcode sweep");
            bop(3'(k), 5'(7 + k), 5'(20 - k), 5'(7 + k), "R6 D equals A");
        end
        bop(3'd7, 5'd12, 5'd12, 5'd12, "R6 xor self clears");
        bop(3'd2, 5'd9, 5'd9, 5'd9, "R6 eqv self sets");
        // R8 priority
        drive(1, 32'hA5A5_0F0F, 1, 32'd3, 32'd4, 3'd2, 1, 1, 3'd5, 5'd0, 5'd1, 5'd31, 3'd0, 2'd0, 1'b1, "R8 load beats compare and bitop");
        drive(0, '0, 1, 32'd3, 32'd4, 3'd1, 0, 1, 3'd4, 5'd3, 5'd3, 5'd30, 3'd7, 2'd2, 1'b1, "R8 compare beats bitop");
        drive(0, '0, 0, '0, '0, 3'd0, 0, 1, 3'd4, 5'd3, 5'd3, 5'd30, 3'd7, 2'd2, 1'b1, "R5 bitop alone lands");
        drive(1, 32'h0000_0000, 0, '0, '0, 3'd0, 0, 0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd4, 2'd1, 1'b0, "R7 R9 load zero");
        drive(1, 32'hFFFF_FFFF, 0, '0, '0, 3'd0, 0, 0, 3'd0, 5'd0, 5'd0, 5'd0, 3'd4, 2'd1, 1'b0, "R7 R9 load ones");
        idle("R7 final hold");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule